// File: doc/BRIEF.md
# Received-Word Packet Grouper

This block sits behind a serial receiver and collects its data words (up to 9 bits each) into packets. A word arrives on a valid/ready input stream. It is appended to an internal buffer, and only then is the buffer tested against two closing conditions. The first condition is that the word just stored equals a programmed delimiter value. The second is that the number of stored words equals a programmed packet length. Each condition has its own enable. When either condition holds, the packet closes.

A closed packet is replayed on a valid/ready output stream in arrival order. Every output beat carries a first-word marker, a final-word marker, the packet length and an overflow flag. The buffer holds 16 words. If it fills and neither condition has fired, the packet is forced closed and flagged as an overflow. The block has one buffer, so it stops taking input while a packet drains.

Back-pressure rules:
- On the input side, a word is taken on any clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is low for the whole time a packet is being drained.
- On the output side, a beat moves on any edge where `out_valid` and `out_ready` are both high.
- While `out_valid` is high and `out_ready` is low, every output field holds its value.

Top module: `pkt_grouper`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: With the delimiter enabled, a stored word equal to `delim_val` closes the packet, and that word is the final word of the packet.
- R3: With the length limit enabled, the packet closes on the word that brings the stored count to `len_val`.
- R4: With both conditions enabled, whichever condition is met first closes the packet.
- R5: A disabled condition has no effect. A delimiter-valued word does not close a packet while the delimiter is disabled, and the count does not close one while the length limit is disabled.
- R6: With both conditions disabled, input words are accepted and discarded. No packet is produced, and nothing remains buffered once a condition is enabled again.
- R7: When 16 words are stored and neither condition holds, the packet closes with `out_overflow` = 1 and `out_count` = 16. `out_overflow` is 0 for every packet closed by the delimiter or the length limit.
- R8: Output words appear in arrival order. `out_first` is 1 only on the first beat and `out_last` is 1 only on the final beat. `out_count` gives the packet length on every beat, and `out_valid` falls after the final beat is taken.
- R9: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_data`, `out_first`, `out_last` and `out_count` keep their values.
- R10: `in_ready` is 0 from the cycle after a packet closes until its final beat is taken, and no input word is taken during that time.
- R11: An enabled length limit of 0 never matches. Such a packet ends only on the delimiter or on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 9 | Received data word |
| delim_en | input | 1 | Enable delimiter closing |
| delim_val | input | 9 | Delimiter value |
| len_en | input | 1 | Enable length closing |
| len_val | input | 5 | Packet length limit |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes beat |
| out_data | output | 9 | Buffered word |
| out_first | output | 1 | First word of packet |
| out_last | output | 1 | Final word of packet |
| out_count | output | 5 | Number of words in packet |
| out_overflow | output | 1 | Packet was forced closed at full buffer |

## Verification
The grouping function is driven with several patterns:
- A delimiter-terminated burst, which shows that the closing word is kept in the packet.
- A length-terminated burst that contains the delimiter value while the delimiter is disabled, which separates the two enables.
- A mixed configuration where the delimiter wins once and the length limit wins once, which shows first-match ordering.
- A long burst with both conditions off, which shows discard without buffering.
- Sixteen-word bursts under a 16 limit, a 0 limit and an absent delimiter, which tell a legitimate full-length close apart from a forced overflow.

A stalled consumer combined with a delimiter word held on the input shows that output fields hold steady and that input is refused during draining.

// File: rtl/pgrp_pkg.sv
package pgrp_pkg;
  typedef enum logic {
    PG_FILL  = 1'b0,
    PG_DRAIN = 1'b1
  } pg_state_e;

  typedef struct packed {
    logic hit_delim;
    logic hit_len;
    logic hit_full;
  } pg_close_t;
endpackage

// File: rtl/pgrp_store.sv
module pgrp_store #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[gi] <= '0;
      end else if (wr_en && (wr_addr == AW'(gi))) begin
        slot_q[gi] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_addr];
endmodule

// File: rtl/pgrp_close_eval.sv
module pgrp_close_eval
  import pgrp_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [CNT_W-1:0]  count_after,
  input  logic              delim_en,
  input  logic [DATA_W-1:0] delim_val,
  input  logic              len_en,
  input  logic [CNT_W-1:0]  len_val,
  output logic              close,
  output logic              forced
);
  pg_close_t why;

  always_comb begin
    why.hit_delim = delim_en && (word == delim_val);
    why.hit_len   = len_en && (len_val != '0) && (count_after == len_val);
    why.hit_full  = (count_after == CNT_W'(DEPTH));
    close  = why.hit_delim || why.hit_len || why.hit_full;
    forced = why.hit_full && !why.hit_delim && !why.hit_len;
  end
endmodule

// File: rtl/pgrp_drain_seq.sv
module pgrp_drain_seq #(
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_len,
  input  logic             take,
  output logic             busy,
  output logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] len,
  output logic             first,
  output logic             last,
  output logic             done
);
  logic [AW-1:0]    ptr_q;
  logic [CNT_W-1:0] len_q;
  logic             busy_q;
  logic [CNT_W-1:0] ptr_ext;

  assign ptr_ext = CNT_W'(ptr_q);
  assign busy    = busy_q;
  assign rd_addr = ptr_q;
  assign len     = len_q;
  assign first   = busy_q && (ptr_q == '0);
  assign last    = busy_q && ((ptr_ext + CNT_W'(1)) == len_q);
  assign done    = busy_q && take && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      len_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
      len_q  <= start_len;
    end else if (busy_q && take) begin
      if (last) begin
        busy_q <= 1'b0;
        ptr_q  <= '0;
      end else begin
        ptr_q <= ptr_q + AW'(1);
      end
    end
  end
endmodule

// File: rtl/pkt_grouper.sv
module pkt_grouper
  import pgrp_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              delim_en,
  input  logic [DATA_W-1:0] delim_val,
  input  logic              len_en,
  input  logic [CNT_W-1:0]  len_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_first,
  output logic              out_last,
  output logic [CNT_W-1:0]  out_count,
  output logic              out_overflow
);
  pg_state_e        state_q;
  logic [CNT_W-1:0] fill_q;
  logic [CNT_W-1:0] fill_next;
  logic             ovf_q;
  logic             wr_en;
  logic             close;
  logic             forced;
  logic             start;
  logic             done;
  logic             busy;
  logic [AW-1:0]    rd_addr;

  assign in_ready  = (state_q == PG_FILL);
  assign wr_en     = in_valid && in_ready && (delim_en || len_en);
  assign fill_next = fill_q + CNT_W'(1);
  assign start     = wr_en && close;

  pgrp_close_eval #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_eval (
    .word        (in_data),
    .count_after (fill_next),
    .delim_en    (delim_en),
    .delim_val   (delim_val),
    .len_en      (len_en),
    .len_val     (len_val),
    .close       (close),
    .forced      (forced)
  );

  pgrp_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (fill_q[AW-1:0]),
    .wr_data (in_data),
    .rd_addr (rd_addr),
    .rd_data (out_data)
  );

  pgrp_drain_seq #(.DEPTH(DEPTH)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_len (fill_next),
    .take      (out_ready),
    .busy      (busy),
    .rd_addr   (rd_addr),
    .len       (out_count),
    .first     (out_first),
    .last      (out_last),
    .done      (done)
  );

  assign out_valid    = busy;
  assign out_overflow = busy && ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_FILL;
      fill_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (start) begin
        state_q <= PG_DRAIN;
        fill_q  <= '0;
        ovf_q   <= forced;
      end else if (wr_en) begin
        fill_q <= fill_next;
      end
      if (done) begin
        state_q <= PG_FILL;
      end
    end
  end
endmodule

// File: rtl/pkt_grouper_chk.sv
module pkt_grouper_chk #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              delim_en,
  input logic              len_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_first,
  input logic              out_last,
  input logic [CNT_W-1:0]  out_count,
  input logic              out_overflow
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
      $stable(out_first) && $stable(out_last) && $stable(out_count));

  assert_no_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_ovf_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |-> out_count == CNT_W'(DEPTH));

  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !delim_en && !len_en && !out_valid |=> !out_valid);

  assert_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  assert_len_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_count != '0);
endmodule

bind pkt_grouper pkt_grouper_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_ready     (in_ready),
  .delim_en     (delim_en),
  .len_en       (len_en),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_first    (out_first),
  .out_last     (out_last),
  .out_count    (out_count),
  .out_overflow (out_overflow)
);

// File: tb/tb_pkt_grouper.sv
`timescale 1ns/1ps
module tb_pkt_grouper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [8:0] in_data = '0;
  logic       delim_en = 1'b0;
  logic [8:0] delim_val = '0;
  logic       len_en = 1'b0;
  logic [4:0] len_val = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [8:0] out_data;
  logic       out_first;
  logic       out_last;
  logic [4:0] out_count;
  logic       out_overflow;

  int n_chk = 0;
  int n_fail = 0;
  logic [8:0] exp_w [16];

  always #2 clk = ~clk;

  pkt_grouper dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [8:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_packet(input int n, input logic ovf, input string req);
    out_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      int tmo = 0;
      while (!out_valid && tmo < 50) begin
        @(negedge clk);
        tmo++;
      end
      chk(out_valid, req, out_valid, 1);
      chk(out_data == exp_w[i], req, out_data, exp_w[i]);
      chk(out_first == (i == 0), {req, " first"}, out_first, i == 0);
      chk(out_last == (i == n - 1), {req, " last"}, out_last, i == n - 1);
      chk(out_count == n, {req, " count"}, out_count, n);
      chk(out_overflow == ovf, {req, " overflow"}, out_overflow, ovf);
      @(negedge clk);
    end
    chk(!out_valid, {req, " R8 end"}, out_valid, 0);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_delim();
    delim_en = 1; delim_val = 9'h00A; len_en = 0;
    exp_w[0] = 9'h011; exp_w[1] = 9'h1FF; exp_w[2] = 9'h00A;
    for (int i = 0; i < 3; i++) send_word(exp_w[i]);
    expect_packet(3, 1'b0, "R2 R8 delimiter close");
  endtask

  task automatic t_length();
    delim_en = 0; delim_val = 9'h00A; len_en = 1; len_val = 5'd4;
    exp_w[0] = 9'h00A; exp_w[1] = 9'h123; exp_w[2] = 9'h00A; exp_w[3] = 9'h07E;
    for (int i = 0; i < 4; i++) send_word(exp_w[i]);
    expect_packet(4, 1'b0, "R3 R5 length close");
  endtask

  task automatic t_first_wins();
    delim_en = 1; delim_val = 9'h055; len_en = 1; len_val = 5'd5;
    exp_w[0] = 9'h001; exp_w[1] = 9'h055;
    for (int i = 0; i < 2; i++) send_word(exp_w[i]);
    expect_packet(2, 1'b0, "R4 delimiter first");
    for (int i = 0; i < 5; i++) exp_w[i] = 9'(9'h100 + i);
    for (int i = 0; i < 5; i++) send_word(exp_w[i]);
    expect_packet(5, 1'b0, "R4 length first");
  endtask

  task automatic t_disabled();
    delim_en = 0; len_en = 0; delim_val = 9'h00A;
    for (int i = 0; i < 20; i++) begin
      send_word(9'(i == 7 ? 9'h00A : 9'h020 + i));
      if (i % 5 == 0) chk(in_ready == 1'b1, "R6 accepting", in_ready, 1);
    end
    repeat (3) @(negedge clk);
    chk(!out_valid, "R6 no packet", out_valid, 0);
    delim_en = 1;
    exp_w[0] = 9'h00A;
    send_word(9'h00A);
    expect_packet(1, 1'b0, "R6 nothing buffered");
  endtask

  task automatic t_overflow();
    delim_en = 1; delim_val = 9'h1FE; len_en = 0;
    for (int i = 0; i < 16; i++) exp_w[i] = 9'(i * 3);
    for (int i = 0; i < 16; i++) send_word(exp_w[i]);
    expect_packet(16, 1'b1, "R7 forced close");
    delim_en = 0; len_en = 1; len_val = 5'd16;
    for (int i = 0; i < 16; i++) exp_w[i] = 9'(9'h080 + i);
    for (int i = 0; i < 16; i++) send_word(exp_w[i]);
    expect_packet(16, 1'b0, "R7 length sixteen no overflow");
    len_val = 5'd0;
    for (int i = 0; i < 16; i++) exp_w[i] = 9'(9'h0C0 + i);
    for (int i = 0; i < 16; i++) send_word(exp_w[i]);
    expect_packet(16, 1'b1, "R11 zero length never matches");
  endtask

  task automatic t_backpressure();
    logic [8:0] held;
    logic       hf;
    delim_en = 1; delim_val = 9'h00A; len_en = 0;
    out_ready = 0;
    exp_w[0] = 9'h033; exp_w[1] = 9'h00A;
    send_word(exp_w[0]);
    send_word(exp_w[1]);
    held = out_data;
    hf = out_first;
    chk(out_valid, "R9 valid", out_valid, 1);
    in_valid = 1; in_data = 9'h00A;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid && out_data == held && out_first == hf, "R9 hold", out_data, held);
      chk(in_ready == 1'b0, "R10 in_ready low", in_ready, 0);
    end
    in_valid = 0;
    expect_packet(2, 1'b0, "R9 R8 after stall");
    repeat (3) @(negedge clk);
    chk(!out_valid, "R10 stalled word not taken", out_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_delim();
    t_length();
    t_first_wins();
    t_disabled();
    t_overflow();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule